// File: doc/BRIEF.md
# I2C Controller Interrupt and Status Register Block

This block holds the event status of an I2C master controller. The protocol engine reports events as single-cycle pulses: no-acknowledge, arbitration lost, access-ready (the programmed transfer ended, with or without error), receive and transmit ready, and receive and transmit draining. Each pulse sets a sticky flag that software clears by writing ones. A live bus-busy level is shown next to the flags. A single interrupt line is raised whenever an enabled flag is set.

Software reaches the block through a 16-bit word register port. There are two status views. The raw view shows every flag plus bus busy, whatever the enables. The masked view shows only the enabled flags. Enables are changed one bit at a time through separate set and clear addresses.

A control register carries the controller-enable bit. When that bit is cleared, the block emits a cancel pulse toward the engine. A soft-reset write returns the block to its idle state and drops a reset-done flag. That flag comes back only when software sets the controller-enable bit again.

Top module: `i2c_irq_regs`

Register map (word addresses): 0 raw status, 1 masked status, 2 enable-set, 3 enable-clear, 4 control, 5 soft-reset command, 6 reset-done status. Flag bits: 0 arbitration lost, 1 no-acknowledge, 2 access-ready, 3 receive ready, 4 transmit ready, 5 receive draining, 6 transmit draining, 12 bus busy (raw view only). Control bit 15 is the controller enable. Soft-reset command bit 0 starts a soft reset. Reset-done status bit 0 is the done flag.

## Requirements
- R1: After hardware reset, all flags, enables and the control register are 0, irq_o is 0, and the reset-done status (address 6) reads 0x0001.
- R2: An event pulse on evt_i[k] sets flag k in the raw view (address 0) from the next cycle on. The flag stays set until it is cleared.
- R3: Writing a 1 to bit k of address 0 or address 1 clears flag k. Writing a 0 leaves the flag unchanged.
- R4: If an event pulse and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R5: Writing ones to address 2 enables those flags, and writing ones to address 3 disables them. Zero bits leave the enables unchanged. Reading address 2 or address 3 returns the current enables.
- R6: Address 1 reads the raw flags ANDed with the enables. irq_o is high exactly when that value is non-zero.
- R7: Bit 12 of the raw view follows bus_busy_i in the same cycle. It never appears in the masked view and is not changed by writes.
- R8: Arbitration lost (bit 0) and no-acknowledge (bit 1) are independent flags, each set and cleared on its own.
- R9: Writing bit 0 of address 5 pulses soft_rst_o for one cycle. It clears the flags, the enables and the control register, and makes address 6 read 0. Address 6 returns to 0x0001 only in the cycle after a control write with bit 15 set.
- R10: A control write that clears bit 15 while it is set drives core_en_o low and pulses cancel_o for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| evt_i | input | 7 | Single-cycle event pulses from the protocol engine |
| bus_busy_i | input | 1 | Live bus-busy level |
| irq_o | output | 1 | Interrupt line |
| core_en_o | output | 1 | Controller enable (control bit 15) |
| cancel_o | output | 1 | One-cycle pulse when the enable is cleared |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse toward the engine |

## Verification
The hardest case to reach is the collision where an event pulse and a write-1 clear target the same flag on the same clock edge. The stimulus table therefore includes a vector that drives the write strobe and the event pulse together in one cycle. The other case is the reset-done handshake, which spans several writes. A directed sequence checks it in order: soft reset first, then a control write without the enable bit (the flag must stay low), then a write with the enable bit set, after which the flag must return.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int DW     = 16;
    localparam int AW     = 3;
    localparam int NEV    = 7;

    localparam logic [AW-1:0] A_RAW  = 3'd0;
    localparam logic [AW-1:0] A_MSK  = 3'd1;
    localparam logic [AW-1:0] A_ISET = 3'd2;
    localparam logic [AW-1:0] A_ICLR = 3'd3;
    localparam logic [AW-1:0] A_CTRL = 3'd4;
    localparam logic [AW-1:0] A_SRST = 3'd5;
    localparam logic [AW-1:0] A_DONE = 3'd6;

    localparam int BUSY_BIT = 12;
    localparam int EN_BIT   = 15;
endpackage

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
    parameter int NEV = i2c_irq_pkg::NEV
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           srst_i,
    input  logic [NEV-1:0] evt_i,
    input  logic [NEV-1:0] clr_i,
    output logic [NEV-1:0] stat_o
);
    typedef struct packed {
        logic [NEV-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // event has priority over a clear of the same bit
        st_d.stat = (st_q.stat & ~clr_i) | evt_i;
        if (srst_i) begin
            st_d.stat = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !srst_i |=> ((st_q.stat & $past(st_q.stat & ~clr_i)) == $past(st_q.stat & ~clr_i)));
    p_evt_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !srst_i |=> ((st_q.stat & $past(evt_i)) == $past(evt_i)));
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.stat & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/i2c_irq_enable.sv
module i2c_irq_enable #(
    parameter int NEV = i2c_irq_pkg::NEV
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           srst_i,
    input  logic [NEV-1:0] set_i,
    input  logic [NEV-1:0] clr_i,
    output logic [NEV-1:0] en_o
);
    typedef struct packed {
        logic [NEV-1:0] en;
    } en_t;

    en_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        en_d.en = (en_q.en | set_i) & ~clr_i;
        if (srst_i) begin
            en_d.en = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= '0;
        else         en_q <= en_d;
    end

    assign en_o = en_q.en;

    p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!srst_i && clr_i == '0) |=> ((en_q.en & $past(set_i)) == $past(set_i)));
    p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((en_q.en & $past(clr_i)) == '0));
endmodule

// File: rtl/i2c_irq_rstseq.sv
module i2c_irq_rstseq #(
    parameter int DW     = i2c_irq_pkg::DW,
    parameter int EN_BIT = i2c_irq_pkg::EN_BIT
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          srst_req_i,
    input  logic          ctrl_wr_i,
    input  logic [DW-1:0] ctrl_wdata_i,
    output logic [DW-1:0] ctrl_o,
    output logic          done_o,
    output logic          cancel_o,
    output logic          srst_o
);
    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic          done;
        logic          cancel;
        logic          pulse;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        rs_d        = rs_q;
        rs_d.cancel = 1'b0;
        rs_d.pulse  = 1'b0;
        if (srst_req_i) begin
            rs_d.ctrl   = '0;
            rs_d.done   = 1'b0;
            rs_d.pulse  = 1'b1;
            rs_d.cancel = rs_q.ctrl[EN_BIT];
        end else if (ctrl_wr_i) begin
            rs_d.ctrl   = ctrl_wdata_i;
            rs_d.cancel = rs_q.ctrl[EN_BIT] & ~ctrl_wdata_i[EN_BIT];
            if (ctrl_wdata_i[EN_BIT]) begin
                rs_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rs_q      <= '0;
            rs_q.done <= 1'b1;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign ctrl_o   = rs_q.ctrl;
    assign done_o   = rs_q.done;
    assign cancel_o = rs_q.cancel;
    assign srst_o   = rs_q.pulse;

    p_done_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rs_q.done) |-> $past(ctrl_wr_i && ctrl_wdata_i[EN_BIT] && !srst_req_i));
    p_srst_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_req_i |=> (!rs_q.done && rs_q.pulse));
    p_cancel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rs_q.cancel |-> (!rs_q.ctrl[EN_BIT] && $past(rs_q.ctrl[EN_BIT])));
endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW,
    parameter int NUM_EV = NEV
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [NUM_EV-1:0] evt_i,
    input  logic              bus_busy_i,
    output logic              irq_o,
    output logic              core_en_o,
    output logic              cancel_o,
    output logic              soft_rst_o
);
    localparam int PAD_W = DATA_W - NUM_EV;

    logic [NUM_EV-1:0] stat, en, masked;
    logic [NUM_EV-1:0] clr_stat, en_set, en_clr;
    logic [DATA_W-1:0] ctrl;
    logic              srst_req, ctrl_wr, done;

    assign srst_req = wr_en_i && (addr_i == A_SRST) && wdata_i[0];
    assign ctrl_wr  = wr_en_i && (addr_i == A_CTRL);
    assign clr_stat = (wr_en_i && (addr_i == A_RAW || addr_i == A_MSK)) ? wdata_i[NUM_EV-1:0] : '0;
    assign en_set   = (wr_en_i && addr_i == A_ISET) ? wdata_i[NUM_EV-1:0] : '0;
    assign en_clr   = (wr_en_i && addr_i == A_ICLR) ? wdata_i[NUM_EV-1:0] : '0;

    i2c_irq_status #(.NEV(NUM_EV)) u_status (
        .clk_i (clk_i), .rst_ni (rst_ni), .srst_i (srst_req),
        .evt_i (evt_i), .clr_i (clr_stat), .stat_o (stat)
    );

    i2c_irq_enable #(.NEV(NUM_EV)) u_enable (
        .clk_i (clk_i), .rst_ni (rst_ni), .srst_i (srst_req),
        .set_i (en_set), .clr_i (en_clr), .en_o (en)
    );

    i2c_irq_rstseq #(.DW(DATA_W), .EN_BIT(EN_BIT)) u_rstseq (
        .clk_i (clk_i), .rst_ni (rst_ni), .srst_req_i (srst_req),
        .ctrl_wr_i (ctrl_wr), .ctrl_wdata_i (wdata_i),
        .ctrl_o (ctrl), .done_o (done), .cancel_o (cancel_o), .srst_o (soft_rst_o)
    );

    assign masked    = stat & en;
    assign irq_o     = |masked;
    assign core_en_o = ctrl[EN_BIT];

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_RAW: begin
                rdata_o = {{PAD_W{1'b0}}, stat};
                rdata_o[BUSY_BIT] = bus_busy_i;
            end
            A_MSK:  rdata_o = {{PAD_W{1'b0}}, masked};
            A_ISET: rdata_o = {{PAD_W{1'b0}}, en};
            A_ICLR: rdata_o = {{PAD_W{1'b0}}, en};
            A_CTRL: rdata_o = ctrl;
            A_DONE: rdata_o[0] = done;
            default: rdata_o = '0;
        endcase
    end

    p_irq_view_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == A_MSK && rdata_o != '0) |-> irq_o);
    p_busy_view_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == A_RAW) |-> (rdata_o[BUSY_BIT] == bus_busy_i));
    p_busy_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == A_MSK) |-> !rdata_o[BUSY_BIT]);
endmodule

// File: tb/i2c_irq_regs_tb.sv
module i2c_irq_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [6:0]  evt = '0;
    logic        busy = 1'b0;
    logic        irq, core_en, cancel, soft_rst;

    int errors = 0;
    int checks = 0;
    bit done_run = 0;

    always #4 clk = ~clk;

    i2c_irq_regs u_dut (
        .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .addr_i (addr),
        .wdata_i (wdata), .rdata_o (rdata), .evt_i (evt), .bus_busy_i (busy),
        .irq_o (irq), .core_en_o (core_en), .cancel_o (cancel), .soft_rst_o (soft_rst)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read-check, 2 event only, 3 write+event
        logic [2:0]  adr;
        logic [15:0] dat;   // write data or expected read data
        logic [6:0]  ev;
        logic        bb;
        logic        xirq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 3'd0, 16'h0000, 7'h00, 1'b0, 1'b0}, // R1 raw zero
        '{2'd1, 3'd6, 16'h0001, 7'h00, 1'b0, 1'b0}, // R1 done set
        '{2'd2, 3'd0, 16'h0000, 7'h02, 1'b0, 1'b0}, // nack event
        '{2'd1, 3'd0, 16'h0002, 7'h00, 1'b0, 1'b0}, // R2 sticky
        '{2'd2, 3'd0, 16'h0000, 7'h01, 1'b0, 1'b0}, // arb lost event
        '{2'd1, 3'd0, 16'h0003, 7'h00, 1'b0, 1'b0}, // R8 both
        '{2'd0, 3'd0, 16'h0001, 7'h00, 1'b0, 1'b0}, // clear AL
        '{2'd1, 3'd0, 16'h0002, 7'h00, 1'b0, 1'b0}, // R3 R8
        '{2'd0, 3'd0, 16'h0000, 7'h00, 1'b0, 1'b0}, // write zero
        '{2'd1, 3'd0, 16'h0002, 7'h00, 1'b0, 1'b0}, // R3 no effect
        '{2'd0, 3'd2, 16'h0006, 7'h00, 1'b0, 1'b0}, // enable nack,ardy
        '{2'd1, 3'd2, 16'h0006, 7'h00, 1'b0, 1'b1}, // R5
        '{2'd1, 3'd1, 16'h0002, 7'h00, 1'b0, 1'b1}, // R6
        '{2'd0, 3'd3, 16'h0002, 7'h00, 1'b0, 1'b0}, // disable nack
        '{2'd1, 3'd3, 16'h0004, 7'h00, 1'b0, 1'b0}, // R5 R6
        '{2'd3, 3'd0, 16'h0004, 7'h04, 1'b0, 1'b0}, // clear+event ardy
        '{2'd1, 3'd0, 16'h0006, 7'h00, 1'b0, 1'b1}, // R4
        '{2'd1, 3'd1, 16'h0004, 7'h00, 1'b0, 1'b1}, // R6
        '{2'd0, 3'd0, 16'hFFFF, 7'h00, 1'b1, 1'b0}, // clear all, busy
        '{2'd1, 3'd0, 16'h1000, 7'h00, 1'b1, 1'b0}, // R7 raw busy
        '{2'd1, 3'd1, 16'h0000, 7'h00, 1'b1, 1'b0}  // R7 masked hides busy
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    initial begin
        for (int w = 0; w < 20000; w++) @(posedge clk);
        if (!done_run) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 irq", {15'd0, irq}, 16'h0);
        check("R1 core_en", {15'd0, core_en}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr = VECS[i].adr;
            busy = VECS[i].bb;
            if (VECS[i].op == 2'd1) begin
                #1;
                check($sformatf("vec%0d rdata", i), rdata, VECS[i].dat);
                check($sformatf("vec%0d irq R6", i), {15'd0, irq}, {15'd0, VECS[i].xirq});
            end else begin
                wdata = VECS[i].dat;
                wr_en = VECS[i].op[0] == 1'b0 || VECS[i].op == 2'd3;
                if (VECS[i].op == 2'd2) wr_en = 1'b0;
                evt   = VECS[i].ev;
                @(posedge clk);
                #1 wr_en = 1'b0; evt = '0;
            end
        end
        busy = 1'b0;

        // R10: enable then disable the controller
        wr(3'd4, 16'h8000);
        check("R10 core_en on", {15'd0, core_en}, 16'h1);
        check("R10 no cancel", {15'd0, cancel}, 16'h0);
        wr(3'd4, 16'h0000);
        check("R10 core_en off", {15'd0, core_en}, 16'h0);
        check("R10 cancel pulse", {15'd0, cancel}, 16'h1);
        @(posedge clk); #1;
        check("R10 cancel one cycle", {15'd0, cancel}, 16'h0);

        // R9: soft reset handshake
        wr(3'd2, 16'h0010);
        wr(3'd4, 16'h8000);
        @(negedge clk); evt = 7'h10; @(posedge clk); #1 evt = '0;
        check("R9 irq before", {15'd0, irq}, 16'h1);
        wr(3'd5, 16'h0001);
        check("R9 soft_rst pulse", {15'd0, soft_rst}, 16'h1);
        check("R9 cancel on reset", {15'd0, cancel}, 16'h1);
        rd(3'd6, v); check("R9 done low", v, 16'h0000);
        rd(3'd0, v); check("R9 flags cleared", v, 16'h0000);
        rd(3'd2, v); check("R9 enables cleared", v, 16'h0000);
        rd(3'd4, v); check("R9 ctrl cleared", v, 16'h0000);
        check("R9 soft_rst one cycle", {15'd0, soft_rst}, 16'h0);
        wr(3'd4, 16'h0001);
        rd(3'd6, v); check("R9 done needs enable", v, 16'h0000);
        wr(3'd4, 16'h8001);
        rd(3'd6, v); check("R9 done back", v, 16'h0001);
        rd(3'd4, v); check("R9 ctrl readback", v, 16'h8001);

        done_run = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule